// File: doc/BRIEF.md
# Serial Command and Result Interface for a Two-Channel Sampling Converter

This block is the device-side digital serial port of a two-channel, 12-bit sampling converter. A host holds the active-low select low and toggles a serial clock. The block ignores every zero on the data input until the first one arrives, which is the start bit. It then reads four command bits. These choose the input pairing, the order in which the result bits go out, and whether the converter enters power-down.

After the command, the block drives the 12-bit result on its data output. The result comes from a parallel port that the converter supplies. Output bits change on falling serial-clock edges, so that the host can sample them on rising edges. The analog front end and the conversion engine lie outside the block.

All logic runs on a fast system clock. The serial clock, the select and the data input are brought in through a parameterised synchroniser and edge detector. Raising the select at any time returns the port to start-bit hunting on the next system clock cycle. The same event releases the output-enable.

Top module: `adc_ser_if`

## Requirements
- R1: After select falls, zeros sampled on rising serial-clock edges are discarded. The first one sampled is the start bit. Output-enable stays low throughout the hunt and the command.
- R2: The four bits after the start bit are, in order: mode (1 = single-ended against ground, 0 = channel pair), channel/sign, order (1 = MSB-first only, 0 = MSB-first then LSB-first), and power (0 = power-down).
- R3: Once the channel/sign bit is captured, `pos_ch` equals that bit and `neg_gnd` equals the mode bit. `pos_ch` names the channel on the positive input. When `neg_gnd` is 1 the negative input is ground; when it is 0 the negative input is the other channel. Both outputs hold until the next command.
- R4: After the power bit, data-input activity has no effect on the output stream or on `pos_ch`/`neg_gnd` until select rises and falls again.
- R5: On the falling edge after the power bit, output-enable rises and a null bit of 0 is driven. The next 12 falling edges drive result bits 11 down to 0. The data output changes only after a falling serial-clock edge while select stays low.
- R6: With order = 1 and power = 1, zeros follow bit 0 for as long as select stays low.
- R7: With order = 0 and power = 1, bit 0 is followed by bits 1 up to 11 (bit 0 is not repeated), then by zeros.
- R8: With power = 0, twelve ones follow the null bit, then zeros, whatever the order bit is. `shutdown` is set at the power-bit capture and holds through select high. It clears on the next select fall.
- R9: When select rises, within 4 system clocks output-enable and the data output go low and the port returns to start-bit hunting. A new frame may begin at once, including one that aborts mid-stream.
- R10: The result is latched on the cycle that captures the power bit. Later changes on `result` do not alter the bits sent.
- R11: After reset, `dout_oe` = 0, `dout` = 0, `pos_ch` = 0, `neg_gnd` = 1 and `shutdown` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, asynchronous to `clk` |
| cs_n | input | 1 | Active-low frame select from the host |
| din | input | 1 | Serial command input |
| result | input | 12 | Parallel conversion result from the converter |
| dout | output | 1 | Serial data output |
| dout_oe | output | 1 | Drive enable for the three-state output pad |
| pos_ch | output | 1 | Channel routed to the positive input (0 or 1) |
| neg_gnd | output | 1 | 1: negative input is ground; 0: the other channel |
| shutdown | output | 1 | Power-down request to the analog section |

## Verification
On every system cycle, the assertions check four things. The data output moves only after a synchronised falling serial edge. Output-enable rises only on such an edge and drops as soon as select is seen high. The channel outputs change only on a rising serial edge. The shutdown flag holds until, and clears on, a select fall. The bench scenarios show what needs a whole frame: the start-bit hunt after varying runs of leading zeros, the exact bit streams for each order and power setting, immunity to data-input noise and to result changes after capture, and a clean restart after a frame is aborted mid-stream.

// File: rtl/adc_ser_pkg.sv
`timescale 1ns/1ps
// Package: shared types and command-field positions for the serial converter port.
// Assumes a four-bit command following a single start bit.
package adc_ser_pkg;

    localparam int CMD_LEN = 4;

    // Order of the command bits after the start bit (the host relies on it).
    localparam int POS_MODE = 0;  // 1 = single-ended, 0 = pair
    localparam int POS_CHAN = 1;  // channel / sign
    localparam int POS_ORD  = 2;  // 1 = MSB-first only
    localparam int POS_PWR  = 3;  // 0 = power-down

    typedef enum logic [1:0] {
        CMD_HUNT,
        CMD_TAKE,
        CMD_DONE
    } cmd_st_t;

    typedef enum logic [2:0] {
        OUT_IDLE,
        OUT_ARMED,
        OUT_NULL,
        OUT_FWD,
        OUT_REV,
        OUT_FILL
    } out_st_t;

endpackage

// File: rtl/adc_ser_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes each input holds a level for more than STAGES+2 system clocks so
// that the bundle's members stay aligned after synchronisation.
module adc_ser_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the raw bundle through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
            stg[0] <= d;
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_ser_edges.sv
`timescale 1ns/1ps
// Module: single-cycle event strobes from the synchronised serial clock and select.
// Assumes inputs are already synchronous to clk.
module adc_ser_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic cs_n_s,
    output logic cs_act,
    output logic cs_fall,
    output logic sclk_rise,
    output logic sclk_fall
);

    logic sclk_prev;
    logic cs_act_prev;

    // Remember last cycle's levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev   <= 1'b0;
            cs_act_prev <= 1'b0;
        end else begin
            sclk_prev   <= sclk_s;
            cs_act_prev <= cs_act;
        end
    end

    assign cs_act    = !cs_n_s;
    assign cs_fall   = cs_act && !cs_act_prev;
    assign sclk_rise = sclk_s && !sclk_prev;
    assign sclk_fall = !sclk_s && sclk_prev;

endmodule

// File: rtl/adc_ser_cmd.sv
`timescale 1ns/1ps
// Module: start-bit hunt and command capture.
// Hunts for the first one after select falls, then takes CMD_LEN bits.
// Drives the input routing and power-down status, and a capture strobe for the
// power bit. Assumes cs_act low forces an immediate return to hunting.
module adc_ser_cmd
    import adc_ser_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_act,
    input  logic cs_fall,
    input  logic sclk_rise,
    input  logic din_s,
    output logic pos_ch,
    output logic neg_gnd,
    output logic shutdown,
    output logic cap_pwr,
    output logic pwr_bit,
    output logic ord_bit
);

    localparam int CW = $clog2(CMD_LEN);

    cmd_st_t        st;
    logic [CW-1:0]  cnt;
    logic           mode_q;
    logic           take_now;

    assign take_now = cs_act && sclk_rise && (st == CMD_TAKE);
    assign cap_pwr  = take_now && (cnt == CW'(POS_PWR));
    assign pwr_bit  = din_s;

    // Command phase sequencing and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= CMD_HUNT;
            cnt     <= '0;
            mode_q  <= 1'b0;
            ord_bit <= 1'b0;
        end else if (!cs_act) begin
            st  <= CMD_HUNT;
            cnt <= '0;
        end else if (sclk_rise) begin
            case (st)
                CMD_HUNT: begin
                    if (din_s) begin
                        st  <= CMD_TAKE;
                        cnt <= '0;
                    end
                end
                CMD_TAKE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(POS_MODE)) mode_q  <= din_s;
                    if (cnt == CW'(POS_ORD))  ord_bit <= din_s;
                    if (cnt == CW'(POS_PWR))  st      <= CMD_DONE;
                end
                default: ;
            endcase
        end
    end

    // Input routing, updated when the channel bit is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_ch  <= 1'b0;
            neg_gnd <= 1'b1;
        end else if (take_now && (cnt == CW'(POS_CHAN))) begin
            pos_ch  <= din_s;
            neg_gnd <= mode_q;
        end
    end

    // Power-down status: set on a zero power bit, cleared by the next select fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown <= 1'b0;
        end else if (cs_fall) begin
            shutdown <= 1'b0;
        end else if (cap_pwr && !din_s) begin
            shutdown <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_ser_out.sv
`timescale 1ns/1ps
// Module: result serialiser.
// Latches the word on the power-bit capture, then on falling serial edges sends
// a null bit, the word MSB-first, optionally bits 1..MSB in ascending order,
// then zeros. Power-down replaces the word by all ones and forces the
// MSB-only order. Assumes cap_pwr and sclk_fall never coincide.
module adc_ser_out
    import adc_ser_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             sclk_fall,
    input  logic             cap_pwr,
    input  logic             pwr_bit,
    input  logic             ord_bit,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe
);

    localparam int IW = $clog2(RES_W);

    out_st_t           st;
    logic [RES_W-1:0]  word;
    logic [IW-1:0]     idx;
    logic              rev_q;

    // Output sequencing on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= OUT_IDLE;
            word    <= '0;
            idx     <= '0;
            rev_q   <= 1'b0;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (!cs_act) begin
            st      <= OUT_IDLE;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
        end else if (cap_pwr) begin
            word  <= pwr_bit ? result : '1;
            rev_q <= pwr_bit && !ord_bit;
            st    <= OUT_ARMED;
        end else if (sclk_fall) begin
            case (st)
                OUT_ARMED: begin
                    st      <= OUT_NULL;
                    dout    <= 1'b0;
                    dout_oe <= 1'b1;
                end
                OUT_NULL: begin
                    st   <= OUT_FWD;
                    idx  <= IW'(RES_W - 1);
                    dout <= word[RES_W-1];
                end
                OUT_FWD: begin
                    if (idx == '0) begin
                        if (rev_q) begin
                            st   <= OUT_REV;
                            idx  <= IW'(1);
                            dout <= word[1];
                        end else begin
                            st   <= OUT_FILL;
                            dout <= 1'b0;
                        end
                    end else begin
                        idx  <= idx - 1'b1;
                        dout <= word[idx - 1'b1];
                    end
                end
                OUT_REV: begin
                    if (idx == IW'(RES_W - 1)) begin
                        st   <= OUT_FILL;
                        dout <= 1'b0;
                    end else begin
                        idx  <= idx + 1'b1;
                        dout <= word[idx + 1'b1];
                    end
                end
                OUT_FILL: dout <= 1'b0;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_ser_if.sv
`timescale 1ns/1ps
// Module: top of the serial command/result port of a two-channel converter.
// Synchronises the host pins, derives edge strobes, decodes the command and
// serialises the result. Assumes each serial-clock level lasts more than
// SYNC_STAGES+2 system clocks.
module adc_ser_if #(
    parameter int RES_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             din,
    input  logic [RES_W-1:0] result,
    output logic             dout,
    output logic             dout_oe,
    output logic             pos_ch,
    output logic             neg_gnd,
    output logic             shutdown
);

    logic [2:0] pins_s;
    logic       cs_act;
    logic       cs_fall;
    logic       sclk_rise;
    logic       sclk_fall;
    logic       cap_pwr;
    logic       pwr_bit;
    logic       ord_bit;

    adc_ser_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, din}),
        .q     (pins_s)
    );

    adc_ser_edges u_edges (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .cs_act    (cs_act),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall)
    );

    adc_ser_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .cs_fall   (cs_fall),
        .sclk_rise (sclk_rise),
        .din_s     (pins_s[0]),
        .pos_ch    (pos_ch),
        .neg_gnd   (neg_gnd),
        .shutdown  (shutdown),
        .cap_pwr   (cap_pwr),
        .pwr_bit   (pwr_bit),
        .ord_bit   (ord_bit)
    );

    adc_ser_out #(
        .RES_W (RES_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .cap_pwr   (cap_pwr),
        .pwr_bit   (pwr_bit),
        .ord_bit   (ord_bit),
        .result    (result),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

endmodule

// File: rtl/adc_ser_if_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for adc_ser_if, attached by bind.
// Assumes the edge strobes it receives are the ones the top's logic uses.
module adc_ser_if_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_act,
    input logic cs_fall,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic dout,
    input logic dout_oe,
    input logic pos_ch,
    input logic neg_gnd,
    input logic shutdown
);

    // R9: select high releases the output on the next cycle.
    a_r9_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (!dout_oe && !dout));

    // R5: within a frame the data output moves only after a falling serial edge.
    a_r5_dout_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$stable(dout)) |-> $past(sclk_fall));

    // R5: the drive enable turns on only after a falling serial edge.
    a_r5_oe_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(sclk_fall));

    // R3: routing outputs change only after a rising serial edge.
    a_r3_routing_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable({pos_ch, neg_gnd}));

    // R8: power-down status holds until a select fall.
    a_r8_shutdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !cs_fall) |=> shutdown);

    // R8: a select fall clears the power-down status.
    a_r8_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> !shutdown);

endmodule

bind adc_ser_if adc_ser_if_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .cs_fall   (cs_fall),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .dout      (dout),
    .dout_oe   (dout_oe),
    .pos_ch    (pos_ch),
    .neg_gnd   (neg_gnd),
    .shutdown  (shutdown)
);

// File: tb/adc_ser_if_test.sv
`timescale 1ns/1ps
// Bench: drives serial frames like a host and compares every sampled bit with a
// queue-based model of the expected stream.
module adc_ser_if_test;

    localparam int HALF = 8;  // system clocks per serial-clock level

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sclk;
    logic        cs_n;
    logic        din;
    logic [11:0] result;
    logic        dout;
    logic        dout_oe;
    logic        pos_ch;
    logic        neg_gnd;
    logic        shutdown;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_ser_if uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .din      (din),
        .result   (result),
        .dout     (dout),
        .dout_oe  (dout_oe),
        .pos_ch   (pos_ch),
        .neg_gnd  (neg_gnd),
        .shutdown (shutdown)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One serial period: fall with new data, sample just before the rise.
    task automatic sclk_cycle(input logic d, output logic got, output logic got_oe);
        sclk = 1'b0;
        din  = d;
        repeat (HALF) @(negedge clk);
        got    = dout;
        got_oe = dout_oe;
        sclk   = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_frame(input int lead, input bit mode, input bit chan, input bit ord,
                             input bit pwr, input logic [11:0] res, input int tail,
                             input bit noise, input bit flip_res, input int abort_at);
        logic  g;
        logic  go;
        logic  exp_q[$];
        string tag_q[$];
        int    n;
        result = res;
        cs_n   = 1'b0;
        repeat (HALF) @(negedge clk);
        chk("R8", "shutdown after select fall", shutdown, 0);
        for (int i = 0; i < lead; i++) begin
            sclk_cycle(1'b0, g, go);
            chk("R1", "oe during hunt", go, 0);
        end
        sclk_cycle(1'b1, g, go);
        chk("R1", "oe at start bit", go, 0);
        sclk_cycle(mode, g, go);
        chk("R2", "oe during command", go, 0);
        sclk_cycle(chan, g, go);
        chk("R2", "oe during command", go, 0);
        sclk_cycle(ord, g, go);
        chk("R2", "oe during command", go, 0);
        sclk_cycle(pwr, g, go);
        chk("R2", "oe during command", go, 0);
        // model of the expected stream
        exp_q.push_back(1'b0);
        tag_q.push_back("R5");
        for (int b = 11; b >= 0; b--) begin
            exp_q.push_back(pwr ? res[b] : 1'b1);
            tag_q.push_back(pwr ? "R5" : "R8");
        end
        if (pwr && !ord) begin
            for (int b = 1; b <= 11; b++) begin
                exp_q.push_back(res[b]);
                tag_q.push_back("R7");
            end
        end
        for (int t = 0; t < tail; t++) begin
            exp_q.push_back(1'b0);
            tag_q.push_back(!pwr ? "R8" : (ord ? "R6" : "R7"));
        end
        n = 0;
        while (exp_q.size() > 0 && n != abort_at) begin
            logic  e;
            string tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            if (flip_res && n == 4) result = ~res;  // R10 stimulus
            sclk_cycle(noise ? logic'((n % 3) != 1) : 1'b0, g, go);
            chk(noise ? {tg, "/R4"} : (flip_res ? {tg, "/R10"} : tg),
                $sformatf("dout bit %0d", n), g, e);
            chk("R5", $sformatf("oe bit %0d", n), go, 1);
            n++;
        end
        chk(noise ? "R3/R4" : "R3", "pos_ch", pos_ch, chan);
        chk(noise ? "R3/R4" : "R3", "neg_gnd", neg_gnd, mode);
        chk("R8", "shutdown in frame", shutdown, !pwr);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9", "oe after select high", dout_oe, 0);
        chk("R9", "dout after select high", dout, 0);
        chk("R8", "shutdown held through select high", shutdown, !pwr);
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        cs_n   = 1'b1;
        sclk   = 1'b0;
        din    = 1'b0;
        result = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "reset oe", dout_oe, 0);
        chk("R11", "reset dout", dout, 0);
        chk("R11", "reset pos_ch", pos_ch, 0);
        chk("R11", "reset neg_gnd", neg_gnd, 1);
        chk("R11", "reset shutdown", shutdown, 0);

        // single-ended CH0, MSB only
        run_frame(0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hA5C, 4, 1'b0, 1'b0, -1);
        // single-ended CH1, MSB then LSB, after leading zeros
        run_frame(3, 1'b1, 1'b1, 1'b0, 1'b1, 12'h3E1, 3, 1'b0, 1'b0, -1);
        // pair CH0+/CH1-, data-input noise after the command
        run_frame(7, 1'b0, 1'b0, 1'b1, 1'b1, 12'h801, 5, 1'b1, 1'b0, -1);
        // pair CH1+/CH0-, result changes after capture
        run_frame(1, 1'b0, 1'b1, 1'b0, 1'b1, 12'h5A6, 2, 1'b0, 1'b1, -1);
        // power-down with reverse order requested
        run_frame(2, 1'b1, 1'b0, 1'b0, 1'b0, 12'h123, 4, 1'b0, 1'b0, -1);
        // immediate next frame, aborted mid-stream
        run_frame(0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h00F, 2, 1'b0, 1'b0, 7);
        // restart right after the abort
        run_frame(0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h6B2, 2, 1'b0, 1'b0, -1);
        // noise plus reverse order
        run_frame(4, 1'b0, 1'b1, 1'b0, 1'b1, 12'hC3A, 3, 1'b1, 1'b0, -1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule